// File: doc/BRIEF.md
# Interrupt CPU Interface with Acknowledge

This block is the per-processor end of an interrupt controller. A distributor offers it one candidate at a time: a valid flag, a 10-bit interrupt ID and an 8-bit priority, where a lower number means a more urgent interrupt. The block compares the candidate against a software priority mask and against the priority of the interrupt currently being serviced. If it may interrupt the processor, the block raises a request line.

Software talks to the block through a simple register bus with word offsets:
- 0x000: control
- 0x004: priority mask
- 0x008: binary point
- 0x00C: acknowledge
- 0x010: end-of-interrupt
- 0x014: running priority
- 0x018: highest pending

Reading acknowledge claims the candidate. The block returns its ID, pushes it onto a small stack of active interrupts, and sends an acknowledge pulse back to the distributor so that the distributor clears the pending state. When nothing qualifies, the read returns the spurious ID 1023. Writing the claimed ID to end-of-interrupt retires it. The block then pulses an end-of-interrupt strobe and restores the previous running priority. A more urgent candidate may preempt the interrupt being serviced, up to `NEST_DEPTH` levels.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, control reads 0, mask reads 0, binary point reads 0, running priority reads 0xFF, highest pending reads 1023 with no candidate, and `irqReq` is low.
- R2: Control bit 0 enables signalling. While it is 0, `irqReq` stays low and an acknowledge read returns 1023.
- R3: `irqReq` is high exactly when control bit 0 is 1, the candidate is valid, its ID is below 1020, and its priority is strictly below both the mask and the running priority, with fewer than `NEST_DEPTH` interrupts active.
- R4: When the R3 condition holds, an acknowledge read returns the candidate ID in bits [9:0] and zero above. In the cycle its data appears, `ackPulse` is high for one cycle with `ackId` equal to that ID, and running priority then reads the candidate's priority.
- R5: When the R3 condition does not hold, an acknowledge read returns 1023, gives no `ackPulse`, and leaves running priority unchanged. A repeated read of the same candidate after it has been acknowledged therefore returns 1023.
- R6: A write to end-of-interrupt whose bits [9:0] equal the most recently acknowledged, still active ID retires it. `eoiPulse` is high for one cycle with `eoiId` equal to that ID, and running priority returns to its value before that acknowledge (0xFF when no interrupt remains active).
- R7: An end-of-interrupt write with any other ID, or with no interrupt active, is ignored: no `eoiPulse`, and running priority is unchanged.
- R8: A highest-pending read returns the candidate ID when it is valid and below 1020, and 1023 otherwise. It has no side effect: no `ackPulse`, and running priority is unchanged.
- R9: Control bit 0, mask bits [7:0] and binary point bits [2:0] read back as written; other bits read 0.
- R10: Up to `NEST_DEPTH` interrupts (default 4) can be active at once, each more urgent than the last. With the stack full, `irqReq` stays low and an acknowledge read returns 1023.
- R11: A candidate ID of 1020 or above is never signalled and never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| candValid | input | 1 | Distributor offers a candidate |
| candId | input | 10 | Candidate interrupt ID |
| candPrio | input | 8 | Candidate priority, lower is more urgent |
| busWrite | input | 1 | Register write strobe |
| busRead | input | 1 | Register read strobe |
| busAddr | input | 12 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered one cycle after the read |
| irqReq | output | 1 | Interrupt request to the processor |
| ackPulse | output | 1 | One-cycle acknowledge notice to the distributor |
| ackId | output | 10 | ID that was acknowledged |
| eoiPulse | output | 1 | One-cycle completion notice to the distributor |
| eoiId | output | 10 | ID that was completed |

## Verification
Read data, `ackPulse` and `eoiPulse` are registered. They are due one cycle after the clock edge that samples the bus strobe, so the bench deasserts the strobe at the next falling edge and samples all three there. Register writes and stack pushes or pops take effect at that same edge. `irqReq` is combinational from that state and the candidate inputs, so the bench samples it a nanosecond after changing the candidate, away from any edge. Ignored writes and side-effect-free reads are judged by reading running priority back and by the absence of pulses.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ID_W = 10;
  localparam int PRIO_W = 8;
  localparam int SPURIOUS_ID = 1023;
  localparam int SPECIAL_BASE = 1020;

  localparam int OFF_CTRL = 'h000;
  localparam int OFF_MASK = 'h004;
  localparam int OFF_BPR = 'h008;
  localparam int OFF_ACK = 'h00C;
  localparam int OFF_EOI = 'h010;
  localparam int OFF_RUN = 'h014;
  localparam int OFF_HPEND = 'h018;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_MASK, SEL_BPR, SEL_ACK, SEL_RUN, SEL_HPEND, SEL_ZERO
  } rdSel_t;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic wrBpr;
    logic push;
    logic pop;
    logic rdLatch;
    rdSel_t rdSel;
  } cpuifStrobes_t;
endpackage

// File: rtl/cpuif_ctrl.sv
module cpuif_ctrl
  import cpuif_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ID_W-1:0]   eoiWdata,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic              ctrlEn,
  input  logic [PRIO_W-1:0] prioMask,
  input  logic [PRIO_W-1:0] runPrio,
  input  logic              stackFull,
  input  logic              stackEmpty,
  input  logic [ID_W-1:0]   topId,
  output cpuifStrobes_t     strb,
  output logic              candReal,
  output logic              irqReq
);
  logic qualify;
  logic rdGo;
  logic hitCtrl, hitMask, hitBpr, hitAck, hitEoi, hitRun, hitHpend;

  assign hitCtrl  = busAddr == ADDR_W'(OFF_CTRL);
  assign hitMask  = busAddr == ADDR_W'(OFF_MASK);
  assign hitBpr   = busAddr == ADDR_W'(OFF_BPR);
  assign hitAck   = busAddr == ADDR_W'(OFF_ACK);
  assign hitEoi   = busAddr == ADDR_W'(OFF_EOI);
  assign hitRun   = busAddr == ADDR_W'(OFF_RUN);
  assign hitHpend = busAddr == ADDR_W'(OFF_HPEND);

  assign candReal = candValid && (candId < ID_W'(SPECIAL_BASE));
  assign qualify  = ctrlEn && candReal && (candPrio < prioMask)
                    && (candPrio < runPrio) && !stackFull;
  assign irqReq   = qualify;
  assign rdGo     = busRead && !busWrite;

  always_comb begin
    strb.wrCtrl  = busWrite && hitCtrl;
    strb.wrMask  = busWrite && hitMask;
    strb.wrBpr   = busWrite && hitBpr;
    strb.pop     = busWrite && hitEoi && !stackEmpty && (eoiWdata == topId);
    strb.push    = rdGo && hitAck && qualify;
    strb.rdLatch = rdGo;
    if (hitCtrl)       strb.rdSel = SEL_CTRL;
    else if (hitMask)  strb.rdSel = SEL_MASK;
    else if (hitBpr)   strb.rdSel = SEL_BPR;
    else if (hitAck)   strb.rdSel = SEL_ACK;
    else if (hitRun)   strb.rdSel = SEL_RUN;
    else if (hitHpend) strb.rdSel = SEL_HPEND;
    else               strb.rdSel = SEL_ZERO;
  end

  AST_DISABLE_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && hitCtrl && !ctrlEn && 1'b1 && !eoiWdata[0]) |=> !irqReq); // R2

  AST_EOI_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && hitEoi && !strb.pop) |=> $stable(runPrio)); // R7
endmodule

// File: rtl/cpuif_dpath.sv
module cpuif_dpath
  import cpuif_pkg::*;
#(
  parameter int NEST_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cpuifStrobes_t     strb,
  input  logic [ID_W-1:0]   wdata,
  input  logic              candReal,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  output logic              ctrlEn,
  output logic [PRIO_W-1:0] prioMask,
  output logic [PRIO_W-1:0] runPrio,
  output logic              stackFull,
  output logic              stackEmpty,
  output logic [ID_W-1:0]   topId,
  output logic [31:0]       rdData,
  output logic              ackPulse,
  output logic [ID_W-1:0]   ackId,
  output logic              eoiPulse,
  output logic [ID_W-1:0]   eoiId
);
  localparam int DEP_W = $clog2(NEST_DEPTH + 1);
  localparam int IDX_W = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1;

  logic [2:0]        binPoint;
  logic [DEP_W-1:0]  depth;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  pushIdx;
  logic [ID_W-1:0]   idStk [NEST_DEPTH];
  logic [PRIO_W-1:0] prStk [NEST_DEPTH];
  logic [31:0]       rdNext;

  assign topIdx     = IDX_W'(depth - DEP_W'(1));
  assign pushIdx    = IDX_W'(depth);
  assign stackEmpty = depth == '0;
  assign stackFull  = depth == DEP_W'(NEST_DEPTH);
  assign runPrio    = stackEmpty ? {PRIO_W{1'b1}} : prStk[topIdx];
  assign topId      = idStk[topIdx];

  for (genvar gi = 0; gi < NEST_DEPTH; gi++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        idStk[gi] <= '0;
        prStk[gi] <= '0;
      end else if (strb.push && pushIdx == IDX_W'(gi)) begin
        idStk[gi] <= candId;
        prStk[gi] <= candPrio;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      prioMask <= '0;
      binPoint <= '0;
      depth    <= '0;
    end else begin
      if (strb.wrCtrl) ctrlEn   <= wdata[0];
      if (strb.wrMask) prioMask <= wdata[PRIO_W-1:0];
      if (strb.wrBpr)  binPoint <= wdata[2:0];
      if (strb.push)      depth <= depth + DEP_W'(1);
      else if (strb.pop)  depth <= depth - DEP_W'(1);
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_CTRL:  rdNext = {31'b0, ctrlEn};
      SEL_MASK:  rdNext = {{(32-PRIO_W){1'b0}}, prioMask};
      SEL_BPR:   rdNext = {29'b0, binPoint};
      SEL_ACK:   rdNext = strb.push ? {{(32-ID_W){1'b0}}, candId} : 32'(SPURIOUS_ID);
      SEL_RUN:   rdNext = {{(32-PRIO_W){1'b0}}, runPrio};
      SEL_HPEND: rdNext = candReal ? {{(32-ID_W){1'b0}}, candId} : 32'(SPURIOUS_ID);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData   <= '0;
      ackPulse <= 1'b0;
      ackId    <= '0;
      eoiPulse <= 1'b0;
      eoiId    <= '0;
    end else begin
      if (strb.rdLatch) rdData <= rdNext;
      ackPulse <= strb.push;
      eoiPulse <= strb.pop;
      if (strb.push) ackId <= candId;
      if (strb.pop)  eoiId <= topId;
    end
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEP_W'(NEST_DEPTH)); // R10

  AST_PUSH_LOWERS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> runPrio < $past(runPrio)); // R4

  AST_POP_RAISES_RUN: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> runPrio > $past(runPrio)); // R6

  AST_ACK_ID_REAL: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> ackId < ID_W'(SPECIAL_BASE)); // R11
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import cpuif_pkg::*;
#(
  parameter int NEST_DEPTH = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqReq,
  output logic              ackPulse,
  output logic [ID_W-1:0]   ackId,
  output logic              eoiPulse,
  output logic [ID_W-1:0]   eoiId
);
  cpuifStrobes_t     strb;
  logic              candReal;
  logic              ctrlEn;
  logic [PRIO_W-1:0] prioMask;
  logic [PRIO_W-1:0] runPrio;
  logic              stackFull;
  logic              stackEmpty;
  logic [ID_W-1:0]   topId;
  logic              unusedWdata;

  assign unusedWdata = ^busWdata[31:ID_W];

  cpuif_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busWrite(busWrite), .busRead(busRead), .busAddr(busAddr),
    .eoiWdata(busWdata[ID_W-1:0]),
    .candValid(candValid), .candId(candId), .candPrio(candPrio),
    .ctrlEn(ctrlEn), .prioMask(prioMask), .runPrio(runPrio),
    .stackFull(stackFull), .stackEmpty(stackEmpty), .topId(topId),
    .strb(strb), .candReal(candReal), .irqReq(irqReq)
  );

  cpuif_dpath #(.NEST_DEPTH(NEST_DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wdata(busWdata[ID_W-1:0]),
    .candReal(candReal), .candId(candId), .candPrio(candPrio),
    .ctrlEn(ctrlEn), .prioMask(prioMask), .runPrio(runPrio),
    .stackFull(stackFull), .stackEmpty(stackEmpty), .topId(topId),
    .rdData(busRdata),
    .ackPulse(ackPulse), .ackId(ackId),
    .eoiPulse(eoiPulse), .eoiId(eoiId)
  );
endmodule

// File: tb/irq_cpu_if_tb_top.sv
`timescale 1ns/1ps
module irq_cpu_if_tb_top;
  localparam int CYC = 20;
  localparam logic [11:0] A_CTRL = 12'h000, A_MASK = 12'h004, A_BPR = 12'h008,
    A_ACK = 12'h00C, A_EOI = 12'h010, A_RUN = 12'h014, A_HPEND = 12'h018;

  typedef struct packed {
    logic       en;
    logic       v;
    logic [9:0] id;
    logic [7:0] pr;
    logic [7:0] mk;
    logic       exp;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b1, 1'b1, 10'd5,    8'h10, 8'hF0, 1'b1},
    '{1'b1, 1'b1, 10'd5,    8'hF0, 8'hF0, 1'b0},
    '{1'b0, 1'b1, 10'd5,    8'h10, 8'hF0, 1'b0},
    '{1'b1, 1'b0, 10'd5,    8'h10, 8'hF0, 1'b0},
    '{1'b1, 1'b1, 10'd1020, 8'h00, 8'hF0, 1'b0},
    '{1'b1, 1'b1, 10'd1019, 8'hEF, 8'hF0, 1'b1},
    '{1'b1, 1'b1, 10'd0,    8'h00, 8'h00, 1'b0},
    '{1'b1, 1'b1, 10'd33,   8'hFE, 8'hFF, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic candValid = 1'b0;
  logic [9:0] candId = '0;
  logic [7:0] candPrio = '0;
  logic busWrite = 1'b0, busRead = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqReq, ackPulse, eoiPulse;
  logic [9:0] ackId, eoiId;

  int total = 0;
  int fails = 0;
  logic done = 1'b0;

  always #(CYC/2) clk = ~clk;

  irq_cpu_if dut_i (
    .clk(clk), .rstN(rstN), .candValid(candValid), .candId(candId),
    .candPrio(candPrio), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqReq(irqReq), .ackPulse(ackPulse), .ackId(ackId),
    .eoiPulse(eoiPulse), .eoiId(eoiId)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    output logic ep, output logic [9:0] eid);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
    ep = eoiPulse; eid = eoiId;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d,
                    output logic ap, output logic [9:0] aid);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
    d = busRdata; ap = ackPulse; aid = ackId;
  endtask

  task automatic setCand(input logic v, input logic [9:0] id, input logic [7:0] pr);
    candValid = v; candId = id; candPrio = pr;
    #1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(CYC * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    logic p;
    logic [9:0] id;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1 chk("R1 irqReq", 32'(irqReq), 0);
    rd(A_CTRL, d, p, id);  chk("R1 ctrl", d, 0);
    rd(A_MASK, d, p, id);  chk("R1 mask", d, 0);
    rd(A_BPR, d, p, id);   chk("R1 bpr", d, 0);
    rd(A_RUN, d, p, id);   chk("R1 runPrio", d, 32'hFF);
    rd(A_HPEND, d, p, id); chk("R1 hpend", d, 1023);

    // R9 readback
    wr(A_BPR, 32'h3, p, id);  rd(A_BPR, d, p, id);  chk("R9 bpr 3", d, 3);
    wr(A_BPR, 32'hFF, p, id); rd(A_BPR, d, p, id);  chk("R9 bpr wide", d, 7);
    wr(A_MASK, 32'h1F0, p, id); rd(A_MASK, d, p, id); chk("R9 mask", d, 32'hF0);
    wr(A_CTRL, 32'h3, p, id); rd(A_CTRL, d, p, id); chk("R9 ctrl", d, 1);

    // R2 ack while disabled
    wr(A_CTRL, 32'h0, p, id);
    setCand(1'b1, 10'd7, 8'h10);
    chk("R2 irq off", 32'(irqReq), 0);
    rd(A_ACK, d, p, id); chk("R2 ack spurious", d, 1023); chk("R2 no pulse", 32'(p), 0);

    // R3 R11 R2 vector walk
    for (int i = 0; i < 8; i++) begin
      wr(A_CTRL, {31'b0, VECS[i].en}, p, id);
      wr(A_MASK, {24'b0, VECS[i].mk}, p, id);
      setCand(VECS[i].v, VECS[i].id, VECS[i].pr);
      chk($sformatf("R3 R11 vector %0d", i), 32'(irqReq), 32'(VECS[i].exp));
    end

    // R4 R5 R8 R6 R7 nesting flow
    wr(A_CTRL, 32'h1, p, id);
    wr(A_MASK, 32'hF0, p, id);
    setCand(1'b1, 10'd40, 8'h80);
    rd(A_ACK, d, p, id);
    chk("R4 ack id", d, 40); chk("R4 ack pulse", 32'(p), 1); chk("R4 ackId", 32'(id), 40);
    rd(A_RUN, d, p, id); chk("R4 runPrio", d, 32'h80);
    #1 chk("R5 irq after ack", 32'(irqReq), 0);
    rd(A_ACK, d, p, id); chk("R5 repeat ack", d, 1023); chk("R5 no pulse", 32'(p), 0);
    rd(A_RUN, d, p, id); chk("R5 runPrio kept", d, 32'h80);

    setCand(1'b1, 10'd41, 8'h40);
    chk("R3 preempt irq", 32'(irqReq), 1);
    rd(A_HPEND, d, p, id); chk("R8 hpend", d, 41); chk("R8 no pulse", 32'(p), 0);
    rd(A_RUN, d, p, id); chk("R8 runPrio kept", d, 32'h80);
    rd(A_ACK, d, p, id); chk("R4 nested ack", d, 41);
    rd(A_RUN, d, p, id); chk("R4 nested runPrio", d, 32'h40);

    wr(A_EOI, 32'd40, p, id); chk("R7 mismatch no pulse", 32'(p), 0);
    rd(A_RUN, d, p, id); chk("R7 runPrio kept", d, 32'h40);
    wr(A_EOI, 32'd41, p, id); chk("R6 eoi pulse", 32'(p), 1); chk("R6 eoiId", 32'(id), 41);
    rd(A_RUN, d, p, id); chk("R6 runPrio restored", d, 32'h80);
    wr(A_EOI, 32'd40, p, id); chk("R6 eoi outer", 32'(p), 1);
    rd(A_RUN, d, p, id); chk("R6 runPrio idle", d, 32'hFF);
    wr(A_EOI, 32'd40, p, id); chk("R7 idle no pulse", 32'(p), 0);
    rd(A_RUN, d, p, id); chk("R7 idle runPrio", d, 32'hFF);

    // R10 stack full
    for (int k = 0; k < 4; k++) begin
      setCand(1'b1, 10'(100 + k), 8'(8'h50 - 8'(16 * k)));
      rd(A_ACK, d, p, id);
      chk($sformatf("R10 fill ack %0d", k), d, 32'(100 + k));
    end
    setCand(1'b1, 10'd104, 8'h10);
    chk("R10 full irq", 32'(irqReq), 0);
    rd(A_ACK, d, p, id); chk("R10 full ack", d, 1023); chk("R10 full no pulse", 32'(p), 0);
    for (int k = 3; k >= 0; k--) begin
      wr(A_EOI, 32'(100 + k), p, id);
      chk($sformatf("R6 unwind %0d", k), 32'(id), 32'(100 + k));
    end
    rd(A_RUN, d, p, id); chk("R6 unwind idle", d, 32'hFF);

    // R8 R11 special ids in highest pending
    setCand(1'b1, 10'd1021, 8'h00);
    rd(A_HPEND, d, p, id); chk("R11 hpend special", d, 1023);
    rd(A_ACK, d, p, id); chk("R11 ack special", d, 1023);
    setCand(1'b0, 10'd9, 8'h00);
    rd(A_HPEND, d, p, id); chk("R8 hpend none", d, 1023);

    done = 1'b1;
    report();
  end
endmodule